// File: doc/BRIEF.md
# Seconds Real-Time Clock with Two Alarms

This core keeps wall time as a 32-bit count of seconds and raises an interrupt for software. A prescaler splits the system clock into a one-second tick and a faster periodic tick. Each tick adds one to the seconds counter. Two alarm units each hold a 32-bit compare value and a small interrupt configuration. When the incremented time matches a compare value, that unit latches an event. A unit can also latch periodic events, either at one per second or at the faster rate. Software reads these events in a status word and clears them by writing ones.

Every register write goes through a settling controller. The write is accepted in one cycle, so the bus never stalls. It is applied only after a fixed number of clocks. The controller is a three-state machine:
- `WS_IDLE` moves to `WS_SETTLE` when a write arrives.
- `WS_SETTLE` moves to `WS_COMMIT` once the settle counter reaches `SETTLE_CYCLES-1`.
- `WS_COMMIT` applies the write for one cycle and then returns to `WS_IDLE`.

The busy output is high in every state other than `WS_IDLE`. Reads are combinational and always return the committed state.

Top module: `sec_rtc_core`

## Requirements
- R1: After reset, every readable register reads 0, `irq` is low and `wr_busy` is low.
- R2: A write that is accepted in idle raises `wr_busy` on the next cycle and holds it for exactly `SETTLE_CYCLES+1` cycles. The target register keeps its old value until `wr_busy` falls.
- R3: A write presented while `wr_busy` is high is dropped. Only the write that was already in flight takes effect.
- R4: The seconds counter (byte offset 0x0C) advances by one every `TICKS_PER_SEC` clocks. When a time write commits, the prescaler restarts, so the next increment comes `TICKS_PER_SEC` cycles after the commit edge. If a time write commits in a tick cycle, the written value wins.
- R5: Alarm 1 (offset 0x10) sets status bit 0, and alarm 2 (offset 0x14) sets status bit 1. The bit is set on the tick whose incremented time equals the compare value, whether or not the alarm interrupt is enabled.
- R6: The status word is at offset 0x00. It has bit 0 for alarm 1 and bit 1 for alarm 2. Bit 2 is the periodic event for the unit configured at 0x04, and bit 3 is the periodic event for the unit configured at 0x08. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. An event that sets a bit in the same cycle that a clear commits keeps the bit set.
- R7: The configuration word for alarm 1 is at 0x04 and for alarm 2 at 0x08. Bit 0 enables the alarm interrupt. Bit 1 enables periodic events. Bit 2, when set, selects one periodic event per second; when clear, the rate is `FAST_HZ` per second. Periodic events are latched only while bit 1 is set.
- R8: `irq` is high exactly while some unit has its alarm bit set together with its bit-0 enable, or its periodic bit set together with its bit-1 enable.
- R9: Offset 0x18 stores a 32-bit calibration word that reads back unchanged. Configuration words read back only bits 2:0. Any other offset reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| wr_busy | output | 1 | A write is settling; new writes are dropped |
| irq | output | 1 | Level interrupt request |

## Verification
Two collisions can happen in the same cycle:
- **Status clear against alarm event.** A time write is placed exactly `TICKS_PER_SEC` clocks before a status clear. The time write sets the counter to one below the alarm value. The status clear therefore commits in the very cycle the alarm tick fires. The alarm bit must stay set. A later clear on its own must then empty it.
- **Time write against second tick.** The second collision is between a time write and a second tick. It is judged at the counter: the counter must only ever step by one or take a committed value.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

    localparam int DATA_W     = 32;
    localparam int NUM_ALARMS = 2;
    localparam int CFG_W      = 3;
    localparam int STAT_W     = 2 * NUM_ALARMS;

    // Register selector; the numeric value equals byte offset / 4
    typedef enum logic [2:0] {
        REG_STAT = 3'd0,
        REG_CFG1 = 3'd1,
        REG_CFG2 = 3'd2,
        REG_TIME = 3'd3,
        REG_ALM1 = 3'd4,
        REG_ALM2 = 3'd5,
        REG_CAL  = 3'd6,
        REG_NONE = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        WS_IDLE   = 2'd0,
        WS_SETTLE = 2'd1,
        WS_COMMIT = 2'd2
    } wstate_e;

    typedef struct packed {
        reg_sel_e          sel;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic reg_sel_e alarm_sel(input int idx);
        return (idx == 0) ? REG_ALM1 : REG_ALM2;
    endfunction

    function automatic reg_sel_e cfg_sel(input int idx);
        return (idx == 0) ? REG_CFG1 : REG_CFG2;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int TICKS_PER_SEC = 250_000_000,
    parameter int FAST_HZ       = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic sec_tick,
    output logic fast_tick
);
    localparam int FAST_DIV = TICKS_PER_SEC / FAST_HZ;
    localparam int SEC_W    = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam int FAST_W   = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;
    localparam logic [SEC_W-1:0]  SEC_LAST  = SEC_W'(TICKS_PER_SEC - 1);
    localparam logic [FAST_W-1:0] FAST_LAST = FAST_W'(FAST_DIV - 1);

    logic [SEC_W-1:0]  sec_cnt_q;
    logic [FAST_W-1:0] fast_cnt_q;

    assign sec_tick  = (sec_cnt_q == SEC_LAST);
    assign fast_tick = (fast_cnt_q == FAST_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            sec_cnt_q  <= '0;
            fast_cnt_q <= '0;
        end else begin
            sec_cnt_q  <= sec_tick  ? '0 : sec_cnt_q + 1'b1;
            fast_cnt_q <= fast_tick ? '0 : fast_cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/rtc_write_settle.sv
module rtc_write_settle
    import sec_rtc_pkg::*;
#(
    parameter int SETTLE_CYCLES = 1250
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  wr_req_t req_in,
    output logic    busy,
    output logic    commit,
    output wr_req_t commit_req
);
    localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

    wstate_e          state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    wr_req_t          hold_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:   if (req_valid) state_d = WS_SETTLE;
            WS_SETTLE: if (cnt_q == CNT_LAST) state_d = WS_COMMIT;
            WS_COMMIT: state_d = WS_IDLE;
            default:   state_d = WS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WS_IDLE;
        else        state_q <= state_d;
    end

    // Captured request and settle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            cnt_q  <= '0;
        end else if (state_q == WS_IDLE) begin
            cnt_q <= '0;
            if (req_valid) hold_q <= req_in;
        end else if (state_q == WS_SETTLE) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        busy       = (state_q != WS_IDLE);
        commit     = (state_q == WS_COMMIT);
        commit_req = hold_q;
    end

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
    import sec_rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_alarm,
    input  logic              wr_cfg,
    input  logic [DATA_W-1:0] alarm_in,
    input  logic [CFG_W-1:0]  cfg_in,
    input  logic              count_ok,
    input  logic [DATA_W-1:0] time_next,
    input  logic              sec_tick,
    input  logic              fast_tick,
    input  logic              clr_alarm,
    input  logic              clr_prd,
    output logic [DATA_W-1:0] alarm_q,
    output logic [CFG_W-1:0]  cfg_q,
    output logic              alarm_flag,
    output logic              prd_flag,
    output logic              irq_req
);
    logic alarm_hit, prd_hit;

    assign alarm_hit = count_ok && (time_next == alarm_q);
    assign prd_hit   = cfg_q[1] && (cfg_q[2] ? sec_tick : fast_tick);
    assign irq_req   = (alarm_flag && cfg_q[0]) || (prd_flag && cfg_q[1]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= '0;
            cfg_q   <= '0;
        end else begin
            if (wr_alarm) alarm_q <= alarm_in;
            if (wr_cfg)   cfg_q   <= cfg_in;
        end
    end

    // Event flags: a new event outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_flag <= 1'b0;
            prd_flag   <= 1'b0;
        end else begin
            if (alarm_hit)      alarm_flag <= 1'b1;
            else if (clr_alarm) alarm_flag <= 1'b0;
            if (prd_hit)        prd_flag   <= 1'b1;
            else if (clr_prd)   prd_flag   <= 1'b0;
        end
    end

endmodule

// File: rtl/sec_rtc_core.sv
module sec_rtc_core
    import sec_rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 250_000_000,
    parameter int FAST_HZ       = 4,
    parameter int SETTLE_CYCLES = 1250,
    parameter int ADDR_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wr_busy,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] LAST_OFFS = ADDR_W'(24);

    reg_sel_e    addr_sel;
    wr_req_t     new_req;
    wr_req_t     cur_req;
    logic        wr_commit;
    logic        time_commit;
    logic        sec_tick, fast_tick;
    logic        count_ok;
    logic [DATA_W-1:0] time_q, time_next, cal_q;
    logic [STAT_W-1:0] stat_vec;
    logic [NUM_ALARMS-1:0][DATA_W-1:0] alm_val;
    logic [NUM_ALARMS-1:0][CFG_W-1:0]  cfg_val;
    logic [NUM_ALARMS-1:0] alm_flag, prd_flag, irq_term;

    // Address decode shared by reads and writes
    always_comb begin
        if (bus_addr[1:0] != 2'b00 || bus_addr > LAST_OFFS) addr_sel = REG_NONE;
        else                                                  addr_sel = reg_sel_e'(bus_addr[4:2]);
    end

    assign new_req.sel  = addr_sel;
    assign new_req.data = bus_wdata;

    rtc_write_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (bus_wr),
        .req_in     (new_req),
        .busy       (wr_busy),
        .commit     (wr_commit),
        .commit_req (cur_req)
    );

    assign time_commit = wr_commit && (cur_req.sel == REG_TIME);

    rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC), .FAST_HZ(FAST_HZ)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (time_commit),
        .sec_tick  (sec_tick),
        .fast_tick (fast_tick)
    );

    assign time_next = time_q + 1'b1;
    assign count_ok  = sec_tick && !time_commit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q <= '0;
            cal_q  <= '0;
        end else begin
            if (time_commit)   time_q <= cur_req.data;
            else if (sec_tick) time_q <= time_next;
            if (wr_commit && cur_req.sel == REG_CAL) cal_q <= cur_req.data;
        end
    end

    for (genvar gi = 0; gi < NUM_ALARMS; gi++) begin : g_alarm
        logic stat_wr;
        assign stat_wr = wr_commit && (cur_req.sel == REG_STAT);

        rtc_alarm_unit u_unit (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_alarm   (wr_commit && (cur_req.sel == alarm_sel(gi))),
            .wr_cfg     (wr_commit && (cur_req.sel == cfg_sel(gi))),
            .alarm_in   (cur_req.data),
            .cfg_in     (cur_req.data[CFG_W-1:0]),
            .count_ok   (count_ok),
            .time_next  (time_next),
            .sec_tick   (sec_tick),
            .fast_tick  (fast_tick),
            .clr_alarm  (stat_wr && cur_req.data[gi]),
            .clr_prd    (stat_wr && cur_req.data[NUM_ALARMS + gi]),
            .alarm_q    (alm_val[gi]),
            .cfg_q      (cfg_val[gi]),
            .alarm_flag (alm_flag[gi]),
            .prd_flag   (prd_flag[gi]),
            .irq_req    (irq_term[gi])
        );
    end

    assign stat_vec = {prd_flag, alm_flag};
    assign irq      = |irq_term;

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        unique case (addr_sel)
            REG_STAT: bus_rdata = DATA_W'(stat_vec);
            REG_CFG1: bus_rdata = DATA_W'(cfg_val[0]);
            REG_CFG2: bus_rdata = DATA_W'(cfg_val[1]);
            REG_TIME: bus_rdata = time_q;
            REG_ALM1: bus_rdata = alm_val[0];
            REG_ALM2: bus_rdata = alm_val[1];
            REG_CAL:  bus_rdata = cal_q;
            REG_NONE: bus_rdata = '0;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sec_rtc_core_chk.sv
module sec_rtc_core_chk #(
    parameter int SETTLE_CYCLES = 1250
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_busy,
    input logic        irq,
    input logic [3:0]  status,
    input logic [31:0] time_q,
    input logic        time_commit,
    input logic        commit
);
    logic [31:0] busy_len;

    always_ff @(posedge clk) begin
        if (!rst_n)       busy_len <= '0;
        else if (wr_busy) busy_len <= busy_len + 1'b1;
        else              busy_len <= '0;
    end

    // R2: busy window length
    a_r2_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_busy) |-> busy_len == 32'(SETTLE_CYCLES + 1));

    // R4: time only steps by one or takes a committed value
    a_r4_time_step: assert property (@(posedge clk) disable iff (!rst_n)
        (time_q != $past(time_q)) |-> ((time_q == $past(time_q) + 32'd1) || $past(time_commit)));

    // R5: an alarm bit rises only together with an increment
    a_r5_alarm_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(status[0]) || $rose(status[1])) |-> time_q == $past(time_q) + 32'd1);

    // R6: a status bit falls only after a committed write
    a_r6_clear_by_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(status) & ~status)) |-> $past(commit));

    // R8: no pending event means no interrupt
    a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 4'b0) |-> !irq);

endmodule

bind sec_rtc_core sec_rtc_core_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_busy     (wr_busy),
    .irq         (irq),
    .status      (stat_vec),
    .time_q      (time_q),
    .time_commit (time_commit),
    .commit      (wr_commit)
);

// File: tb/sec_rtc_core_tb_top.sv
`timescale 1ns/1ps
module sec_rtc_core_tb_top;
    localparam int TPS    = 64;
    localparam int FHZ    = 4;
    localparam int SETTLE = 8;

    localparam logic [7:0] A_STAT = 8'h00, A_CFG1 = 8'h04, A_CFG2 = 8'h08, A_TIME = 8'h0C,
                           A_ALM1 = 8'h10, A_ALM2 = 8'h14, A_CAL = 8'h18, A_HOLE = 8'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wr_busy;
    logic        irq;

    always #2 clk = ~clk;

    sec_rtc_core #(.TICKS_PER_SEC(TPS), .FAST_HZ(FHZ), .SETTLE_CYCLES(SETTLE), .ADDR_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wr_busy(wr_busy), .irq(irq)
    );

    typedef struct {
        int          kind;   // 0 read data, 1 irq, 2 busy
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t exp_q[$];
    logic  smp_req = 1'b0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;

    // Monitor: pops an expected item and compares against the design
    always @(negedge clk) begin
        if (smp_req && exp_q.size() > 0) begin
            item_t       it;
            logic [31:0] act;
            it  = exp_q.pop_front();
            act = (it.kind == 0) ? bus_rdata : (it.kind == 1) ? {31'b0, irq} : {31'b0, wr_busy};
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic expect_item(input int kind, input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.kind = kind; it.exp = e; it.tag = tag;
        @(posedge clk); #1;
        bus_addr = a;
        exp_q.push_back(it);
        smp_req = 1'b1;
        @(posedge clk); #1;
        smp_req = 1'b0;
    endtask

    task automatic direct_check(input logic [31:0] act, input logic [31:0] e, input string tag);
        n_chk++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, e);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        while (wr_busy) @(negedge clk);
    endtask

    task automatic wr_wait(input logic [7:0] a, input logic [31:0] d);
        bus_write(a, d);
        settle();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int blen;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int k = 0; k < 7; k++) expect_item(0, 8'(4 * k), 32'h0, "R1 register reset");
        expect_item(1, A_STAT, 32'h0, "R1 irq reset");
        expect_item(2, A_STAT, 32'h0, "R1 busy reset");

        // R9: calibration store, cfg width, unmapped hole
        wr_wait(A_CAL, 32'hA5A5_1234);
        expect_item(0, A_CAL, 32'hA5A5_1234, "R9 calibration readback");
        wr_wait(A_CFG1, 32'hFFFF_FFFF);
        expect_item(0, A_CFG1, 32'h7, "R9 cfg width");
        wr_wait(A_CFG1, 32'h0);
        wr_wait(A_HOLE, 32'hDEAD_BEEF);
        expect_item(0, A_HOLE, 32'h0, "R9 unmapped reads zero");

        // R2: busy length and deferred commit
        bus_write(A_ALM1, 32'd100);
        blen = 0;
        @(negedge clk);
        while (wr_busy) begin blen++; @(negedge clk); end
        direct_check(32'(blen), 32'(SETTLE + 1), "R2 busy length");
        bus_write(A_ALM2, 32'h55);
        expect_item(0, A_ALM2, 32'h0, "R2 old value while busy");
        settle();
        expect_item(0, A_ALM2, 32'h55, "R2 value after settle");

        // R3: write during busy dropped
        bus_write(A_ALM2, 32'd5);
        bus_write(A_ALM2, 32'd7);
        settle();
        expect_item(0, A_ALM2, 32'd5, "R3 busy write dropped");
        expect_item(2, A_STAT, 32'h0, "R3 no second commit");

        // R4: counting and prescaler restart on time write
        wr_wait(A_TIME, 32'd1000);
        repeat (TPS - 4) @(negedge clk);
        expect_item(0, A_TIME, 32'd1000, "R4 no step before a full second");
        repeat (6) @(negedge clk);
        expect_item(0, A_TIME, 32'd1001, "R4 step after a full second");

        // R5: alarm 1 event with interrupt disabled
        wr_wait(A_STAT, 32'hF);
        wr_wait(A_TIME, 32'd99);
        wr_wait(A_STAT, 32'hF);
        repeat (TPS + 4) @(negedge clk);
        expect_item(0, A_STAT, 32'h1, "R5 alarm1 latched");
        expect_item(1, A_STAT, 32'h0, "R8 masked alarm gives no irq");
        wr_wait(A_CFG1, 32'h1);
        expect_item(1, A_STAT, 32'h1, "R8 enabled alarm drives irq");

        // R6: writing zeros and unset bits leaves status alone
        wr_wait(A_STAT, 32'h0);
        expect_item(0, A_STAT, 32'h1, "R6 zero write harmless");
        wr_wait(A_STAT, 32'h2);
        expect_item(0, A_STAT, 32'h1, "R6 other bit write harmless");

        // R6: clear commits in the very cycle alarm 1 fires
        bus_write(A_TIME, 32'd99);
        repeat (TPS - 1) @(posedge clk);
        bus_write(A_STAT, 32'h1);
        settle();
        expect_item(0, A_STAT, 32'h1, "R6 event wins over clear");
        expect_item(0, A_TIME, 32'd100, "R4 time after collision");
        wr_wait(A_STAT, 32'h1);
        expect_item(0, A_STAT, 32'h0, "R6 plain clear");
        expect_item(1, A_STAT, 32'h0, "R8 irq drops after clear");

        // R5: alarm 2
        wr_wait(A_ALM2, 32'd200);
        wr_wait(A_TIME, 32'd199);
        repeat (TPS + 4) @(negedge clk);
        expect_item(0, A_STAT, 32'h2, "R5 alarm2 latched");
        wr_wait(A_STAT, 32'h2);

        // R7: fast periodic on unit 2
        wr_wait(A_CFG2, 32'h2);
        repeat (20) @(negedge clk);
        expect_item(0, A_STAT, 32'h8, "R7 fast periodic latched");
        expect_item(1, A_STAT, 32'h1, "R8 periodic drives irq");
        wr_wait(A_CFG2, 32'h0);
        wr_wait(A_STAT, 32'h8);
        repeat (40) @(negedge clk);
        expect_item(0, A_STAT, 32'h0, "R7 disabled periodic stays clear");
        expect_item(1, A_STAT, 32'h0, "R8 irq low with nothing pending");

        // R7: one-per-second periodic on unit 1
        wr_wait(A_CFG1, 32'h6);
        wr_wait(A_TIME, 32'd500);
        wr_wait(A_STAT, 32'h4);
        repeat (20) @(negedge clk);
        expect_item(0, A_STAT, 32'h0, "R7 1Hz not at fast rate");
        repeat (40) @(negedge clk);
        expect_item(0, A_STAT, 32'h4, "R7 1Hz event after one second");
        expect_item(1, A_STAT, 32'h1, "R8 1Hz periodic drives irq");

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule